// File: doc/BRIEF.md
# Oversampled Serial Word Receiver

This block accepts a serial bit stream from a sender that drives its own bit clock, a data line and an active-high envelope. None of these lines is related to the local system clock. Only the bit clock is brought into the local domain, through a chain of synchronizing flip-flops. A rising transition seen at the end of that chain, together with an envelope that has been registered once, produces a single-cycle capture strobe. On each strobe the data line is sampled directly into a shift register, and a bit counter advances.

The sender changes data and envelope on the rising bit-clock edge. The receiver captures on that same edge. This works because the synchronizer adds at least two system cycles of latency, and by the time the strobe fires the data and envelope have long settled. The system clock must run at least four times faster than the bit clock. When a full word has arrived, it is loaded into the output register and a one-cycle valid pulse is raised.

The output is a valid-only stream with no back-pressure. There is no ready input. A consumer must take `word_o` in the cycle `word_valid_o` is high. The word then stays on `word_o` until the next complete word replaces it.

Top module: `serial_word_rx`

## Requirements
- R1: While `rst_n_i` is low, `word_o` is all zeros and `word_valid_o` is low, and both stay so until a full word is received.
- R2: The data level present on `ext_data_i` when `ext_clk_i` rises is the bit captured for that period. The first bit of a word lands in `word_o[WORD_W-1]` (the MSB) and the last bit lands in bit 0.
- R3: `word_valid_o` is high for exactly one system cycle per completed word.
- R4: Bit-clock rising edges that occur while the envelope is low capture nothing: no valid pulse, and `word_o` is unchanged.
- R5: When the envelope goes low, any partly collected word is discarded. The next envelope starts a fresh word from its first bit.
- R6: `word_o` changes only in the cycle in which `word_valid_o` is high.
- R7: Each bit-clock period yields exactly one capture, however many system cycles its high and low phases last.
- R8: Several words may follow back to back inside one envelope. Each group of `WORD_W` bits produces its own word and its own valid pulse. This holds down to a bit-clock period of four system cycles, with two cycles high and two cycles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local system clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | Sender's bit clock, asynchronous |
| ext_data_i | input | 1 | Serial data, changes on the rising edge of `ext_clk_i` |
| ext_env_i | input | 1 | Active-high word envelope, changes on the rising edge of `ext_clk_i` |
| word_o | output | WORD_W | Last completed word, first bit in the MSB |
| word_valid_o | output | 1 | One-cycle pulse marking a newly loaded `word_o` |

## Verification
The bench holds the bit clock high for many system cycles. A receiver that acted on the level instead of the edge would capture the same bit repeatedly and finish words early. The bench also drops the envelope after a few bits and then sends a new word. A receiver that did not clear its count would emit a word mixing stale and fresh bits, and at the wrong moment. Edges sent with the envelope low, and runs at the minimum four-cycle period, expose a receiver that ignores the envelope or that samples data before the sender's rising-edge change is captured. Back-to-back words expose a counter that fails to wrap after the last bit.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned SRX_WORD_W_DEF = 16;
  localparam int unsigned SRX_SYNC_DEF   = 2;
endpackage

// File: rtl/srx_sync_edge.sv
module srx_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              dly_q;

  // Synchronizer chain: the asynchronous input feeds stage 0 only.
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= async_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) dly_q <= 1'b0;
    else dly_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~dly_q;
endmodule

// File: rtl/srx_assembler.sv
module srx_assembler #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              env_q_i,
  input  logic              cap_en_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] shift_nx;

  // New bit enters at bit 0; older bits move toward the MSB.
  assign shift_nx = {shift_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      shift_q <= '0;
      cnt_o   <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!env_q_i) begin
        shift_q <= '0;
        cnt_o   <= '0;
      end else if (cap_en_i) begin
        shift_q <= shift_nx;
        if (cnt_o == LAST) begin
          cnt_o   <= '0;
          word_o  <= shift_nx;
          valid_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
  parameter int unsigned WORD_W      = srx_pkg::SRX_WORD_W_DEF,
  parameter int unsigned SYNC_STAGES = srx_pkg::SRX_SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              ext_clk_i,
  input  logic              ext_data_i,
  input  logic              ext_env_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic             clk_rise;
  logic             env_q;
  logic             cap_en;
  logic [CNT_W-1:0] bit_cnt;

  srx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .async_i (ext_clk_i),
    .rise_o  (clk_rise)
  );

  // The envelope gets a single register; it has settled long before the
  // synchronized clock edge arrives.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) env_q <= 1'b0;
    else env_q <= ext_env_i;
  end

  assign cap_en = clk_rise & env_q;

  srx_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .env_q_i  (env_q),
    .cap_en_i (cap_en),
    .bit_i    (ext_data_i),
    .word_o   (word_o),
    .valid_o  (word_valid_o),
    .cnt_o    (bit_cnt)
  );
endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              cap_en,
  input logic              env_q,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o
);
  // R3
  valid_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    word_valid_o |=> !word_valid_o);

  // R6
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !word_valid_o |-> $stable(word_o));

  // R7
  single_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cap_en |=> !cap_en);

  // R4
  valid_needs_env_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    word_valid_o |-> $past(env_q));

  // R5
  env_low_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !env_q |=> (bit_cnt == '0));
endmodule

bind serial_word_rx srx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_n_i      (rst_n_i),
  .cap_en       (cap_en),
  .env_q        (env_q),
  .bit_cnt      (bit_cnt),
  .word_o       (word_o),
  .word_valid_o (word_valid_o)
);

// File: tb/tb_serial_word_rx.sv
module tb_serial_word_rx;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         eclk = 1'b0;
  logic         edat = 1'b0;
  logic         eenv = 1'b0;
  logic [W-1:0] word;
  logic         valid;

  int errors = 0;
  int checks = 0;
  int vcount = 0;
  int dbl = 0;
  logic         prev_v = 1'b0;
  logic [W-1:0] hist [8];
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_word_rx #(.WORD_W(W)) dut (
    .clk_i(clk), .rst_n_i(rst_n), .ext_clk_i(eclk), .ext_data_i(edat),
    .ext_env_i(eenv), .word_o(word), .word_valid_o(valid)
  );

  // Monitor samples away from the active edge.
  always @(negedge clk) begin
    if (valid) begin
      hist[vcount % 8] = word;
      vcount++;
      if (prev_v) dbl++;
    end
    prev_v = valid;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input logic env, input int hi, input int lo);
    @(negedge clk);
    eclk = 1'b1; edat = b; eenv = env;
    wait_clk(hi);
    eclk = 1'b0;
    wait_clk(lo);
  endtask

  task automatic send_word(input logic [W-1:0] w, input logic env, input int hi, input int lo);
    for (int i = W-1; i >= 0; i--) send_bit(w[i], env, hi, lo);
  endtask

  task automatic env_off();
    @(negedge clk); eenv = 1'b0;
    wait_clk(6);
  endtask

  task automatic test_reset();
    chk(word == '0, "R1 word after reset", 32'(word), 0);
    chk(valid == 1'b0, "R1 valid after reset", 32'(valid), 0);
  endtask

  task automatic test_basic();
    int v0 = vcount;
    send_word(16'hA5C3, 1'b1, 3, 3);
    wait_clk(4);
    chk(vcount == v0 + 1, "R2 one word received", 32'(vcount - v0), 1);
    chk(word == 16'hA5C3, "R2 MSB-first word", 32'(word), 32'hA5C3);
    env_off();
  endtask

  task automatic test_idle_edges();
    int v0 = vcount;
    send_word(16'hFFFF, 1'b0, 3, 3);
    wait_clk(4);
    chk(vcount == v0, "R4 no valid with envelope low", 32'(vcount - v0), 0);
    chk(word == 16'hA5C3, "R4/R6 word unchanged", 32'(word), 32'hA5C3);
  endtask

  task automatic test_partial();
    int v0 = vcount;
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1, 3, 3);
    chk(word == 16'hA5C3, "R6 word held mid-word", 32'(word), 32'hA5C3);
    env_off();
    send_word(16'h1234, 1'b1, 3, 3);
    wait_clk(4);
    chk(vcount == v0 + 1, "R5 one word after dropped partial", 32'(vcount - v0), 1);
    chk(word == 16'h1234, "R5 partial discarded", 32'(word), 32'h1234);
    env_off();
  endtask

  task automatic test_long_high();
    int v0 = vcount;
    send_word(16'h0F0F, 1'b1, 20, 6);
    wait_clk(4);
    chk(vcount == v0 + 1, "R7 one capture per period", 32'(vcount - v0), 1);
    chk(word == 16'h0F0F, "R7 word with long high phase", 32'(word), 32'h0F0F);
    env_off();
  endtask

  task automatic test_back_to_back();
    int v0 = vcount;
    send_word(16'hBEEF, 1'b1, 3, 3);
    send_word(16'h0001, 1'b1, 3, 3);
    wait_clk(4);
    chk(vcount == v0 + 2, "R8 two words in one envelope", 32'(vcount - v0), 2);
    chk(hist[v0 % 8] == 16'hBEEF, "R8 first word", 32'(hist[v0 % 8]), 32'hBEEF);
    chk(word == 16'h0001, "R8 second word", 32'(word), 32'h0001);
    env_off();
  endtask

  task automatic test_min_rate();
    int v0 = vcount;
    send_word(16'h8001, 1'b1, 2, 2);
    send_word(16'h7FFE, 1'b1, 2, 2);
    wait_clk(4);
    chk(vcount == v0 + 2, "R8 words at four-cycle period", 32'(vcount - v0), 2);
    chk(word == 16'h7FFE && hist[v0 % 8] == 16'h8001, "R2/R8 data at minimum period",
        32'(word), 32'h7FFE);
    env_off();
  endtask

  initial begin
    wait_clk(3);
    test_reset();
    @(negedge clk); rst_n = 1'b1;
    wait_clk(3);
    test_basic();
    test_idle_edges();
    test_partial();
    test_long_high();
    test_back_to_back();
    test_min_rate();
    chk(dbl == 0, "R3 valid lasts one cycle", 32'(dbl), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule